// File: doc/BRIEF.md
# Backplane Frame Pulse and Bit Clock Generator

This block derives two backplane timing signals from a fast master clock: a bit clock at one eighth of the master rate with an even duty cycle, and an active-low frame strobe that repeats once per frame of bit-clock periods. With the default parameters the master clock runs at 65.536 MHz, the bit clock at 8.192 MHz, and the frame is 1024 bit periods, which is 125 µs. The frame boundary is the bit-clock rising edge that falls inside the low strobe. The strobe is low for one bit period, with that rising edge at its centre.

Both outputs come from one divider chain. A reference-kind input sets how the divider is aligned:
- With an 8 kHz reference, each rising edge of the reference moves the boundary onto that edge.
- With a 1.544 MHz or 2.048 MHz reference, the divider runs free and the boundary position is arbitrary.
- With an 8.192 MHz reference, the divider follows the falling edge of one of two external frame strobes, picked by a select input.

Every alignment source passes through a synchroniser before it is used. An alignment event that matches the position the divider already holds leaves the waveform unchanged.

Top module: `fpg_frame_gen`

## Requirements
- R1: While `rst_n` is low, `bit_clk` is 0 and `frame_n` is 1. The divider is held at the last master cycle of bit 0, so the first master edge after release raises `bit_clk` with `frame_n` still high.
- R2: Without alignment events, `bit_clk` is high for DIV_RATIO/2 master cycles and then low for DIV_RATIO/2 master cycles.
- R3: `frame_n` is low for exactly DIV_RATIO master cycles. It falls while `bit_clk` is low, and `bit_clk` rises exactly DIV_RATIO/2 cycles after the fall, which is the frame boundary.
- R4: Without alignment events, falling edges of `frame_n` are FRAME_BITS*DIV_RATIO master cycles apart.
- R5: With `ref_kind`=0 (8 kHz), if `ref_in` is first sampled high at master edge k, then after edge k+SYNC_STAGES `bit_clk` is 1 and `frame_n` is 0. That edge is the frame boundary, and the frame restarts from it.
- R6: With `ref_kind`=1 (1.544 MHz) or 2 (2.048 MHz), `ref_in`, `fp_a_n` and `fp_b_n` have no effect on the outputs.
- R7: With `ref_kind`=3 (8.192 MHz), if the selected strobe (`fp_sel`=0 selects `fp_a_n`, 1 selects `fp_b_n`) is first sampled low at edge k, then after edge k+SYNC_STAGES `frame_n` is 0 and `bit_clk` is 0. The boundary follows DIV_RATIO/2 cycles later.
- R8: An external strobe whose alignment lands on the position the divider already holds changes neither output in any cycle.
- R9: With `ref_kind`=3 the unselected strobe and `ref_in` are ignored. With `ref_kind`=0 both strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_kind | input | 2 | Reference kind: 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 8.192 MHz |
| ref_in | input | 1 | Reference signal; its rising edge aligns the frame when `ref_kind` is 0 |
| fp_a_n | input | 1 | External frame strobe A, active low |
| fp_b_n | input | 1 | External frame strobe B, active low |
| fp_sel | input | 1 | Strobe select: 0 = A, 1 = B |
| bit_clk | output | 1 | Bit clock at master/DIV_RATIO, 50% duty |
| frame_n | output | 1 | Active-low frame strobe |

## Verification
The bench builds the block with DIV_RATIO=8 and SYNC_STAGES=2, which match the defaults. It shortens FRAME_BITS to 16, so a frame lasts 128 master cycles. The short frame lets the bench observe many wraps of the bit counter, and strobes landing on, near and far from the expected position, inside a short run. A behavioural position counter in the bench predicts both outputs on every cycle, so each check of a single edge is backed by continuous comparison.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    typedef enum logic [1:0] {
        REF_8K  = 2'd0,
        REF_1M5 = 2'd1,
        REF_2M  = 2'd2,
        REF_8M  = 2'd3
    } ref_kind_e;
endpackage

// File: rtl/fpg_src_mux.sv
module fpg_src_mux
    import fpg_pkg::*;
(
    input  ref_kind_e kind_i,
    input  logic      ref_i,
    input  logic      fp_a_n_i,
    input  logic      fp_b_n_i,
    input  logic      fp_sel_i,
    output logic      src_o,
    output logic      tgt_frame_o
);
    logic fp_pick_n;

    always_comb begin
        fp_pick_n   = fp_sel_i ? fp_b_n_i : fp_a_n_i;
        tgt_frame_o = (kind_i == REF_8M);
        unique case (kind_i)
            REF_8K:  src_o = ref_i;
            REF_8M:  src_o = ~fp_pick_n;
            default: src_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpg_edge_sync.sv
module fpg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    output logic edge_o
);
    // chain_q[0..STAGES-1] synchronise, chain_q[STAGES] holds previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], src_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/fpg_divider.sv
module fpg_divider #(
    parameter int DIV_RATIO  = 8,
    parameter int FRAME_BITS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic load_frame_i,
    output logic bit_clk_o,
    output logic frame_n_o
);
    localparam int PW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam int BW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
    localparam logic [PW-1:0] HALF_P   = PW'(DIV_RATIO / 2);
    localparam logic [PW-1:0] LAST_PH  = PW'(DIV_RATIO - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic [BW-1:0] bitno;
        logic          bclk;
        logic          fn;
    } div_state_t;

    div_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            if (load_frame_i) begin
                s_d.bitno = LAST_BIT;
                s_d.phase = HALF_P;
            end else begin
                s_d.bitno = '0;
                s_d.phase = '0;
            end
        end else if (s_q.phase == LAST_PH) begin
            s_d.phase = '0;
            s_d.bitno = (s_q.bitno == LAST_BIT) ? '0 : s_q.bitno + 1'b1;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
        s_d.bclk = (s_d.phase < HALF_P);
        s_d.fn   = !(((s_d.bitno == '0) && (s_d.phase < HALF_P)) ||
                     ((s_d.bitno == LAST_BIT) && (s_d.phase >= HALF_P)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= LAST_PH;
            s_q.bitno <= '0;
            s_q.bclk  <= 1'b0;
            s_q.fn    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_clk_o = s_q.bclk;
    assign frame_n_o = s_q.fn;

    // R4
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase <= LAST_PH) && (s_q.bitno <= LAST_BIT));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (s_q.phase == (($past(s_q.phase) == LAST_PH) ? '0
                                    : $past(s_q.phase) + 1'b1)));

    // R2
    fall_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.bclk) |-> (s_q.phase == HALF_P));

    // R3
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.bclk) && !s_q.fn) |-> (s_q.bitno == '0));
endmodule

// File: rtl/fpg_frame_gen.sv
module fpg_frame_gen
    import fpg_pkg::*;
#(
    parameter int DIV_RATIO   = 8,
    parameter int FRAME_BITS  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_kind,
    input  logic       ref_in,
    input  logic       fp_a_n,
    input  logic       fp_b_n,
    input  logic       fp_sel,
    output logic       bit_clk,
    output logic       frame_n
);
    ref_kind_e kind;
    logic      src;
    logic      tgt_frame;
    logic      sync_edge;

    assign kind = ref_kind_e'(ref_kind);

    fpg_src_mux u_mux (
        .kind_i      (kind),
        .ref_i       (ref_in),
        .fp_a_n_i    (fp_a_n),
        .fp_b_n_i    (fp_b_n),
        .fp_sel_i    (fp_sel),
        .src_o       (src),
        .tgt_frame_o (tgt_frame)
    );

    fpg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src),
        .edge_o (sync_edge)
    );

    fpg_divider #(.DIV_RATIO(DIV_RATIO), .FRAME_BITS(FRAME_BITS)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (sync_edge),
        .load_frame_i (tgt_frame),
        .bit_clk_o    (bit_clk),
        .frame_n_o    (frame_n)
    );

    // R5
    ref_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_edge && kind == REF_8K) |=> (bit_clk && !frame_n));

    // R7
    fp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_edge && kind == REF_8M) |=> (!bit_clk && !frame_n));

    // R6
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REF_1M5 || kind == REF_2M) |-> !src);
endmodule

// File: tb/tb_fpg_frame_gen.sv
module tb_fpg_frame_gen;
    localparam int DIV   = 8;
    localparam int BITS  = 16;
    localparam int SYNC  = 2;
    localparam int HALF  = DIV / 2;
    localparam int TOTAL = DIV * BITS;
    localparam int WD    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_kind = 2'd1;
    logic       ref_in = 1'b0;
    logic       fp_a_n = 1'b1;
    logic       fp_b_n = 1'b1;
    logic       fp_sel = 1'b0;
    logic       bit_clk, frame_n;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    cmp_en = 1'b0;
    string cur_req = "R2";

    int m_pos = DIV - 1;
    bit hist [0:SYNC];
    bit src_now, ev;

    always #2 clk = ~clk;

    fpg_frame_gen #(.DIV_RATIO(DIV), .FRAME_BITS(BITS), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .ref_kind(ref_kind), .ref_in(ref_in),
        .fp_a_n(fp_a_n), .fp_b_n(fp_b_n), .fp_sel(fp_sel),
        .bit_clk(bit_clk), .frame_n(frame_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural position model: pos = bit index * DIV + master phase
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = DIV - 1;
            for (int i = 0; i <= SYNC; i++) hist[i] = 1'b0;
        end else begin
            if (ref_kind == 2'd0)      src_now = ref_in;
            else if (ref_kind == 2'd3) src_now = fp_sel ? !fp_b_n : !fp_a_n;
            else                       src_now = 1'b0;
            ev = hist[SYNC-1] && !hist[SYNC];
            if (ev) m_pos = (ref_kind == 2'd3) ? TOTAL - HALF : 0;
            else    m_pos = (m_pos + 1) % TOTAL;
            for (int i = SYNC; i >= 1; i--) hist[i] = hist[i-1];
            hist[0] = src_now;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(bit_clk == ((m_pos % DIV) < HALF), cur_req, bit_clk, (m_pos % DIV) < HALF);
            chk(frame_n == !(m_pos < HALF || m_pos >= TOTAL - HALF), cur_req,
                frame_n, !(m_pos < HALF || m_pos >= TOTAL - HALF));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_frame_fall();
        bit prev;
        prev = frame_n;
        cyc(1);
        while (!(prev && !frame_n)) begin
            prev = frame_n;
            cyc(1);
        end
    endtask

    initial begin
        int lowc, per, hic, loc, cnt;
        // R1 reset state
        cyc(4);
        chk(bit_clk == 1'b0, "R1", bit_clk, 0);
        chk(frame_n == 1'b1, "R1", frame_n, 1);
        rst_n = 1'b1;
        cyc(1);
        chk(bit_clk == 1'b1 && frame_n == 1'b1, "R1", {bit_clk, frame_n}, 3);
        cmp_en = 1'b1;

        // free run: R2, R3, R4
        cur_req = "R4";
        cyc(2 * TOTAL);
        wait_frame_fall();
        chk(bit_clk == 1'b0, "R3", bit_clk, 0);
        lowc = 0;
        while (!frame_n) begin
            if (lowc == HALF) chk(bit_clk == 1'b1, "R3", bit_clk, 1);
            lowc++;
            cyc(1);
        end
        chk(lowc == DIV, "R3", lowc, DIV);
        per = lowc;
        while (frame_n) begin per++; cyc(1); end
        chk(per == TOTAL, "R4", per, TOTAL);
        while (bit_clk) cyc(1);
        while (!bit_clk) cyc(1);
        hic = 0; while (bit_clk) begin hic++; cyc(1); end
        loc = 0; while (!bit_clk) begin loc++; cyc(1); end
        chk(hic == HALF, "R2", hic, HALF);
        chk(loc == HALF, "R2", loc, HALF);

        // R5: 8 kHz reference edges at arbitrary positions
        ref_kind = 2'd0;
        cur_req  = "R5";
        for (int i = 0; i < 5; i++) begin
            cyc(23 + i * 37);
            ref_in = 1'b1;
            cyc(SYNC + 1);
            chk(bit_clk == 1'b1 && frame_n == 1'b0, "R5", {bit_clk, frame_n}, 2);
            cyc(10);
            ref_in = 1'b0;
            // R9: strobes ignored with 8 kHz reference
            cur_req = "R9";
            cyc(17);
            fp_a_n = 1'b0; fp_b_n = 1'b0;
            cyc(6);
            fp_a_n = 1'b1; fp_b_n = 1'b1;
            cur_req = "R5";
        end

        // R6: free-running kinds ignore all alignment inputs
        for (int k = 1; k <= 2; k++) begin
            cyc(5);
            ref_kind = 2'(k);
            cur_req  = "R6";
            for (int i = 0; i < 12; i++) begin
                cyc(7 + i * 3);
                ref_in = ~ref_in;
                fp_a_n = (i % 3) != 0;
                fp_b_n = (i % 2) != 0;
            end
            ref_in = 1'b0; fp_a_n = 1'b1; fp_b_n = 1'b1;
            cyc(2 * TOTAL);
        end
        wait_frame_fall();
        per = 0;
        while (!frame_n) begin per++; cyc(1); end
        while (frame_n) begin per++; cyc(1); end
        chk(per == TOTAL, "R6", per, TOTAL);

        // R7: external strobe alignment via A then B
        ref_kind = 2'd3;
        for (int s = 0; s < 2; s++) begin
            cyc(3);
            fp_sel = s[0];
            for (int i = 0; i < 4; i++) begin
                cur_req = "R9";
                cyc(13);
                if (s == 0) fp_b_n = 1'b0; else fp_a_n = 1'b0;
                ref_in = 1'b1;
                cyc(5);
                fp_b_n = 1'b1; fp_a_n = 1'b1; ref_in = 1'b0;
                cur_req = "R7";
                cyc(31 + i * 41);
                if (s == 0) fp_a_n = 1'b0; else fp_b_n = 1'b0;
                cyc(SYNC + 1);
                chk(bit_clk == 1'b0 && frame_n == 1'b0, "R7", {bit_clk, frame_n}, 0);
                cyc(HALF);
                chk(bit_clk == 1'b1 && frame_n == 1'b0, "R7", {bit_clk, frame_n}, 2);
                cyc(DIV - HALF - SYNC - 1);
                fp_a_n = 1'b1; fp_b_n = 1'b1;
            end
        end

        // R8: strobe exactly at the expected position
        cur_req = "R8";
        wait_frame_fall();
        cnt = 0;
        while (m_pos != TOTAL - HALF - SYNC - 1) begin cnt++; cyc(1); end
        chk(frame_n == 1'b1, "R8", frame_n, 1);
        fp_b_n = 1'b0;
        cyc(SYNC + 1);
        cnt = cnt + SYNC + 1;
        chk(cnt == TOTAL, "R8", cnt, TOTAL);
        chk(frame_n == 1'b0 && bit_clk == 1'b0, "R8", {bit_clk, frame_n}, 0);
        lowc = 0;
        while (!frame_n) begin lowc++; cyc(1); end
        chk(lowc == DIV, "R8", lowc, DIV);
        fp_b_n = 1'b1;
        cyc(TOTAL);

        cmp_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule